// File: doc/BRIEF.md
# Conversion Frame Sequencer

This block sets the timing of the digital side of a multi-slope converter. It runs from the raw oscillator clock and divides it by four to give the system period. Each conversion is framed as a fixed run of system periods. A busy output is high for the integration part of the frame. When busy falls, a result-valid window opens. A one-cycle clear strobe resets the result counters half a system period before the next conversion begins. The analog phases are outside the block. A count-enable input stands in for them, and the block gates it into a per-period step pulse for the result counters.

Two modes are selected by a plain level input. In demand mode, one conversion runs for each falling edge of the write strobe seen while chip select is high. The result is then held valid until the next trigger. In continuous mode, frames follow one another back to back with no trigger. The valid window then has a fixed length. All pins are plain control and status levels. There is no streamed data path, so no valid/ready handshake or back-pressure applies.

Top module: `conv_sequencer`

## Requirements
- R1: `sys_tick` is high for exactly one oscillator cycle in every four, and never on two consecutive cycles.
- R2: While `rst` is high, and on the first sample after it, `busy`, `result_valid`, `cnt_clear` and `cnt_step` are all low.
- R3: In demand mode, a falling `wr_n` sampled while `chip_sel` is high puts `cnt_clear` high on the next cycle. `busy` rises two cycles after that clear and stays high for 3344 oscillator cycles (836 system periods).
- R4: In continuous mode, successive rises of `busy` are 5120 oscillator cycles apart (1280 system periods).
- R5: `result_valid` rises in the same cycle that `busy` falls, and is never high together with `busy`.
- R6: In continuous mode, `result_valid` stays high for 1774 oscillator cycles (443.5 system periods). It drops in the cycle where `cnt_clear` pulses for one cycle, and `busy` rises two cycles after that pulse.
- R7: In demand mode, `result_valid` stays high after the frame ends until the next accepted trigger. That trigger's `cnt_clear` cycle shows `result_valid` low.
- R8: A write strobe while a conversion is running, or with `chip_sel` low, has no effect: no `cnt_clear`, no change to `busy` length, and `result_valid` unchanged.
- R9: `cnt_step` equals `count_en` AND `busy` AND `sys_tick`, so it gives 836 steps per conversion when `count_en` is held high and none when it is low.
- R10: Dropping `cont_mode` during a continuous frame lets that frame finish with no clear. The block then goes idle with `result_valid` held high and `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Undivided oscillator clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cont_mode | input | 1 | 1 = continuous conversions, 0 = demand conversions |
| chip_sel | input | 1 | Active-high chip select qualifying the write strobe |
| wr_n | input | 1 | Active-low write strobe; its falling edge triggers a demand conversion |
| count_en | input | 1 | Stand-in for the analog phase enabling the result counters |
| sys_tick | output | 1 | One-cycle pulse closing each system period (divide by four) |
| busy | output | 1 | High while a conversion frame is integrating |
| result_valid | output | 1 | High while the result counters hold a readable result |
| cnt_clear | output | 1 | One-cycle reset strobe for the result counters |
| cnt_step | output | 1 | One-cycle advance pulse for the result counters |

## Verification
The checker assumes that `chip_sel`, `wr_n` and `cont_mode` are synchronous to the oscillator clock and that `rst` is held for at least one edge. Its busy-length counter also assumes that `busy` only ever rises from the idle or prestart path. The bench changes every input half a cycle away from the rising edge. It holds each write strobe low for one full cycle and changes mode only in idle, or mid-frame for the return-to-demand case. It leaves at least one full frame between demand triggers that are meant to be accepted.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PRE  = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sc_clk_div.sv
module sc_clk_div #(
  parameter int DIV_LOG2 = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [DIV_LOG2-1:0] load_val,
  output logic [DIV_LOG2-1:0] phase,
  output logic                tick
);
  localparam logic [DIV_LOG2-1:0] PH_LAST = '1;

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (load) phase <= load_val;
    else           phase <= phase + 1'b1;
  end

  assign tick = (phase == PH_LAST);
endmodule

// File: rtl/sc_frame_ctr.sv
module sc_frame_ctr #(
  parameter int FRAME_PER = 1280,
  parameter int FW        = $clog2(FRAME_PER)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          advance,
  output logic [FW-1:0] count,
  output logic          at_last
);
  localparam logic [FW-1:0] LAST = FW'(FRAME_PER - 1);

  always_ff @(posedge clk) begin
    if (rst || clear)  count <= '0;
    else if (advance)  count <= at_last ? '0 : count + 1'b1;
  end

  assign at_last = (count == LAST);
endmodule

// File: rtl/sc_trigger.sv
module sc_trigger (
  input  logic clk,
  input  logic rst,
  input  logic chip_sel,
  input  logic wr_n,
  output logic fire
);
  logic wr_n_q;

  always_ff @(posedge clk) begin
    if (rst) wr_n_q <= 1'b1;
    else     wr_n_q <= wr_n;
  end

  assign fire = chip_sel && !wr_n && wr_n_q;
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int DIV_LOG2     = 2,
  parameter int FRAME_PER    = 1280,
  parameter int VALID_HALVES = 887
) (
  input  logic clk_osc,
  input  logic rst,
  input  logic cont_mode,
  input  logic chip_sel,
  input  logic wr_n,
  input  logic count_en,
  output logic sys_tick,
  output logic busy,
  output logic result_valid,
  output logic cnt_clear,
  output logic cnt_step
);
  localparam int DIV      = 1 << DIV_LOG2;
  localparam int FW       = $clog2(FRAME_PER);
  localparam int BUSY_PER = FRAME_PER - (VALID_HALVES + 1) / 2;
  localparam logic [DIV_LOG2-1:0] HALF_PH  = DIV_LOG2'(DIV / 2);
  localparam logic [FW-1:0]       BUSY_END = FW'(BUSY_PER);
  localparam logic [FW-1:0]       BUSY_LST = FW'(BUSY_PER - 1);

  seq_state_t          state;
  logic                again;
  logic                held;
  logic                fire;
  logic                start;
  logic                clr_pre;
  logic                clr_run;
  logic [DIV_LOG2-1:0] phase;
  logic                tick;
  logic [FW-1:0]       period;
  logic                at_last;
  logic                frame_end;

  sc_trigger u_trig (
    .clk      (clk_osc),
    .rst      (rst),
    .chip_sel (chip_sel),
    .wr_n     (wr_n),
    .fire     (fire)
  );

  sc_clk_div #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk      (clk_osc),
    .rst      (rst),
    .load     (start),
    .load_val (HALF_PH),
    .phase    (phase),
    .tick     (tick)
  );

  sc_frame_ctr #(.FRAME_PER(FRAME_PER), .FW(FW)) u_frame (
    .clk     (clk_osc),
    .rst     (rst),
    .clear   (state == SEQ_PRE),
    .advance ((state == SEQ_RUN) && tick),
    .count   (period),
    .at_last (at_last)
  );

  // Leaving idle parks the divider half a period before the frame start.
  assign start     = (state == SEQ_IDLE) && (cont_mode || fire);
  assign clr_pre   = (state == SEQ_PRE) && (phase == HALF_PH);
  assign clr_run   = (state == SEQ_RUN) && at_last && (phase == HALF_PH) && cont_mode;
  assign frame_end = (state == SEQ_RUN) && at_last && tick;

  always_ff @(posedge clk_osc) begin
    if (rst) begin
      state <= SEQ_IDLE;
      again <= 1'b0;
      held  <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: if (start) state <= SEQ_PRE;
        SEQ_PRE:  if (tick)  state <= SEQ_RUN;
        SEQ_RUN:  if (frame_end && !again) state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase

      if (clr_run)        again <= 1'b1;
      else if (frame_end) again <= 1'b0;

      if (cnt_clear) held <= 1'b0;
      else if ((state == SEQ_RUN) && tick && (period == BUSY_LST)) held <= 1'b1;
    end
  end

  assign sys_tick     = tick;
  assign busy         = (state == SEQ_RUN) && (period < BUSY_END);
  assign cnt_clear    = clr_pre || clr_run;
  assign result_valid = held && !cnt_clear;
  assign cnt_step     = count_en && busy && tick;
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int DIV_LOG2     = 2,
  parameter int FRAME_PER    = 1280,
  parameter int VALID_HALVES = 887
) (
  input logic clk_osc,
  input logic rst,
  input logic sys_tick,
  input logic busy,
  input logic result_valid,
  input logic cnt_clear,
  input logic cnt_step
);
  localparam int BUSY_OSC = (FRAME_PER - (VALID_HALVES + 1) / 2) * (1 << DIV_LOG2);
  localparam int LW       = $clog2(FRAME_PER * (1 << DIV_LOG2)) + 1;

  logic [LW-1:0] busy_len;

  always_ff @(posedge clk_osc) begin
    if (rst || !busy) busy_len <= '0;
    else              busy_len <= busy_len + 1'b1;
  end

  a_r1_tick_single: assert property (@(posedge clk_osc) disable iff (rst)
    sys_tick |=> !sys_tick);

  a_r3_busy_length: assert property (@(posedge clk_osc) disable iff (rst)
    $fell(busy) |-> (busy_len == LW'(BUSY_OSC)));

  a_r5_valid_at_fall: assert property (@(posedge clk_osc) disable iff (rst)
    $fell(busy) |-> result_valid);

  a_r5_not_both: assert property (@(posedge clk_osc) disable iff (rst)
    !(busy && result_valid));

  a_r6_clr_pulse: assert property (@(posedge clk_osc) disable iff (rst)
    cnt_clear |=> !cnt_clear);

  a_r6_clr_drops_valid: assert property (@(posedge clk_osc) disable iff (rst)
    cnt_clear |-> !result_valid);

  a_r6_clr_before_busy: assert property (@(posedge clk_osc) disable iff (rst)
    $rose(busy) |-> $past(cnt_clear, 2));

  a_r9_step_gated: assert property (@(posedge clk_osc) disable iff (rst)
    cnt_step |-> (busy && sys_tick));
endmodule

bind conv_sequencer conv_sequencer_chk #(
  .DIV_LOG2     (DIV_LOG2),
  .FRAME_PER    (FRAME_PER),
  .VALID_HALVES (VALID_HALVES)
) u_chk (
  .clk_osc      (clk_osc),
  .rst          (rst),
  .sys_tick     (sys_tick),
  .busy         (busy),
  .result_valid (result_valid),
  .cnt_clear    (cnt_clear),
  .cnt_step     (cnt_step)
);

// File: tb/conv_sequencer_bench.sv
module conv_sequencer_bench;
  logic clk_osc = 1'b0;
  logic rst = 1'b1, cont_mode = 1'b0, chip_sel = 1'b0, wr_n = 1'b1, count_en = 1'b0;
  logic sys_tick, busy, result_valid, cnt_clear, cnt_step;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_osc = ~clk_osc;

  conv_sequencer u_conv_sequencer (
    .clk_osc(clk_osc), .rst(rst), .cont_mode(cont_mode), .chip_sel(chip_sel),
    .wr_n(wr_n), .count_en(count_en), .sys_tick(sys_tick), .busy(busy),
    .result_valid(result_valid), .cnt_clear(cnt_clear), .cnt_step(cnt_step)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk_osc);
    check({busy, result_valid, cnt_clear, cnt_step} == 4'b0, "R2 in reset",
          int'({busy, result_valid, cnt_clear, cnt_step}), 0);
    rst = 1'b0;
    @(negedge clk_osc);
    check({busy, result_valid, cnt_clear, cnt_step} == 4'b0, "R2 after reset",
          int'({busy, result_valid, cnt_clear, cnt_step}), 0);
  endtask

  task automatic t_tick();
    int ticks = 0, pairs = 0;
    logic prev = sys_tick;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_osc);
      ticks += int'(sys_tick);
      if (prev && sys_tick) pairs++;
      prev = sys_tick;
    end
    check(ticks == 4, "R1 tick count", ticks, 4);
    check(pairs == 0, "R1 tick adjacency", pairs, 0);
  endtask

  // Triggers one demand conversion; pokes a second strobe mid-busy.
  task automatic t_demand(input logic en, input int exp_steps, input string tag);
    int hi = 0, steps = 0, clrs = 0, idle_bad = 0;
    count_en = en;
    chip_sel = 1'b1; wr_n = 1'b0;
    @(negedge clk_osc);
    check(cnt_clear == 1'b1, {"R3 clear after trigger ", tag}, int'(cnt_clear), 1);
    check(result_valid == 1'b0, {"R7 valid dropped at trigger ", tag}, int'(result_valid), 0);
    wr_n = 1'b1;
    @(negedge clk_osc);
    check(busy == 1'b0, {"R3 busy not yet ", tag}, int'(busy), 0);
    @(negedge clk_osc);
    check(busy == 1'b1, {"R3 busy two after clear ", tag}, int'(busy), 1);
    while (busy && hi < 10000) begin
      hi++;
      steps += int'(cnt_step);
      clrs += int'(cnt_clear);
      if (hi == 1000) wr_n = 1'b0;
      if (hi == 1001) wr_n = 1'b1;
      @(negedge clk_osc);
    end
    check(hi == 3344, {"R3 busy length ", tag}, hi, 3344);
    check(result_valid == 1'b1, {"R5 valid at busy fall ", tag}, int'(result_valid), 1);
    check(steps == exp_steps, {"R9 step count ", tag}, steps, exp_steps);
    check(clrs == 0, {"R8 strobe during busy ", tag}, clrs, 0);
    for (int i = 0; i < 1900; i++) begin
      if (busy || cnt_clear || !result_valid) idle_bad++;
      @(negedge clk_osc);
    end
    check(idle_bad == 0, {"R7 valid held after frame ", tag}, idle_bad, 0);
    chip_sel = 1'b0;
  endtask

  task automatic t_cs_low();
    int bad = 0;
    chip_sel = 1'b0; wr_n = 1'b0;
    @(negedge clk_osc);
    wr_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (busy || cnt_clear || !result_valid) bad++;
      @(negedge clk_osc);
    end
    check(bad == 0, "R8 strobe without chip select", bad, 0);
  endtask

  task automatic t_continuous();
    int rises = 0, last_rise = -1, last_clr = -100, per_bad = 0, gap_bad = 0;
    int vstart = -1, runs = 0, run_bad = 0, fall_bad = 0;
    logic pb, pv;
    count_en = 1'b1;
    cont_mode = 1'b1;
    pb = busy; pv = result_valid;
    for (int i = 0; i < 3 * 5120 + 200; i++) begin
      @(negedge clk_osc);
      if (cnt_clear) last_clr = i;
      if (busy && !pb) begin
        rises++;
        if (i - last_clr != 2) gap_bad++;
        if (last_rise >= 0 && i - last_rise != 5120) per_bad++;
        last_rise = i;
      end
      if (!busy && pb && !result_valid) fall_bad++;
      if (result_valid && !pv) vstart = i;
      if (!result_valid && pv && vstart >= 0) begin
        runs++;
        if (i - vstart != 1774) run_bad++;
      end
      pb = busy; pv = result_valid;
    end
    check(rises >= 3, "R4 continuous frames seen", rises, 4);
    check(per_bad == 0, "R4 busy period", per_bad, 0);
    check(gap_bad == 0, "R6 clear two before busy", gap_bad, 0);
    check(runs >= 2, "R6 valid windows seen", runs, 3);
    check(run_bad == 0, "R6 valid window length", run_bad, 0);
    check(fall_bad == 0, "R5 valid at busy fall (continuous)", fall_bad, 0);
  endtask

  task automatic t_back_to_demand();
    int rises = 0, clrs = 0, guard = 0;
    logic pb;
    while (!busy && guard < 6000) begin
      guard++;
      @(negedge clk_osc);
    end
    cont_mode = 1'b0;
    pb = busy;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk_osc);
      if (busy && !pb) rises++;
      clrs += int'(cnt_clear);
      pb = busy;
    end
    check(rises == 0, "R10 no new frame", rises, 0);
    check(clrs == 0, "R10 no clear", clrs, 0);
    check(result_valid == 1'b1, "R10 valid held", int'(result_valid), 1);
  endtask

  initial begin
    @(negedge clk_osc);
    t_reset();
    t_tick();
    t_demand(1'b1, 836, "counting");
    t_cs_low();
    t_demand(1'b0, 0, "gated");
    t_continuous();
    t_back_to_demand();
    report();
  end

  initial begin
    repeat (150000) @(posedge clk_osc);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end
endmodule